// File: doc/BRIEF.md
# Six-Way Fixed-Priority Bus Arbiter

This block hands out ownership of a shared parallel bus to one of six requesters. Each requester has an active-low request line and gets back an active-low grant line. The priority order never changes. It is built from a balanced tree of two-input decision nodes, and at every node the input on side 0 wins. The result is that requester 0 always beats the others and requester 5 loses to all of them.

Grants change hands only at clean points: when the bus is idle (cycle-start and initiator-ready lines both high) or after the current owner has used its allowance of data phases. A free cycle with no grant always sits between two different owners. When nobody is asking for the bus, it can be parked in one of three ways: on the most recent owner, on a fixed index, or on nobody. A strap input, sampled while reset is held, switches the whole arbiter on or off.

A programmable limit caps the number of data phases per grant. A data phase is a cycle in which the initiator-ready and target-ready lines are both low. A limit of zero means there is no cap.

Top module: `pci_tree_arbiter`

## Requirements
- R1: The strap input is captured while reset is low. If it was 0, every grant output stays high for the whole run, whatever the requests.
- R2: At most one grant output is low at any time. All grants are high during reset and directly after it.
- R3: A grant given because of requests goes to the lowest-numbered requester whose request line is low at the clock edge that issues it.
- R4: A grant is issued from the no-grant state at a clock edge only if, at that edge, the bus is idle (cycle-start and initiator-ready both high) or the previous grant was removed by the transfer limit.
- R5: While the bus is busy and the owner has not reached its limit, the owner keeps its grant, even when a higher-priority request arrives.
- R6: When ownership passes between two different requesters, at least one cycle with all grants high lies between them.
- R7: Parking mode field (2 bits), used when no request is pending: 0 and 3 mean no parking, so all grants go high; 1 means park on the last owner, which is index 0 after reset; 2 means park on the index given by the 3-bit park index, where a park index of 6 or 7 acts as no parking.
- R8: A data phase is a cycle in which initiator-ready and target-ready are both low while a grant is held. With a limit L other than 0, the grant is still held on the edge that counts the L-th data phase and is removed on the edge after it. L = 0 never removes a grant.
- R9: From the no-grant state with an idle bus, the grant appears on the first clock edge. If the bus is idle and the chosen target differs from the owner, the grant is removed on one edge and the new one is issued on the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| strap_arb_en | input | 1 | Enable strap; 1 turns the arbiter on |
| req_n | input | 6 | Active-low requests, index 0 highest priority |
| frame_n | input | 1 | Active-low cycle-start line of the bus |
| irdy_n | input | 1 | Active-low initiator-ready line |
| trdy_n | input | 1 | Active-low target-ready line |
| park_mode | input | 2 | Parking mode select (see R7) |
| park_idx | input | 3 | Fixed parking index |
| xfer_limit | input | 8 | Data phases per grant, 0 means unlimited |
| gnt_n | output | 6 | Active-low grants, at most one low |

## Verification
Directed sequences come first. Overlapping request sets tell the priority order apart from any round-robin behaviour. A higher request raised during a busy bus separates hold-while-busy from eager preemption. A counted burst of data phases checks that the grant drops on exactly the edge after the limit, and that the next owner then wins even though the bus is still busy. Each parking mode, and an out-of-range park index, is tried with no requests pending. These show apart the three idle behaviours: release, stay with the last owner, and move to a fixed index. A long random run then mixes requests, bus activity, limits and parking settings. At every new grant the bench compares the winner against the lowest pending request or the parking target, and in every cycle it checks the one-hot property, the gap between owners and holding while busy.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_OFF   = 2'd3
  } park_e;

  // mask of all indices strictly below idx
  function automatic logic [31:0] below_mask(input logic [31:0] idx);
    return (32'd1 << idx) - 32'd1;
  endfunction

  // limit reached: zero limit never reached
  function automatic logic limit_reached(input logic [31:0] cnt, input logic [31:0] lim);
    return (lim != 32'd0) && (cnt >= lim);
  endfunction

endpackage

// File: rtl/arb_node.sv
module arb_node #(
  parameter int IW = 3
) (
  input  logic          v0,
  input  logic [IW-1:0] i0,
  input  logic          v1,
  input  logic [IW-1:0] i1,
  output logic          v,
  output logic [IW-1:0] i
);
  // side 0 always wins when valid
  assign v = v0 | v1;
  assign i = v0 ? i0 : i1;
endmodule

// File: rtl/arb_tree.sv
module arb_tree #(
  parameter int N  = 6,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          win_vld,
  output logic [IW-1:0] win_idx
);
  localparam int LEAVES = 1 << IW;
  localparam int NODES  = 2 * LEAVES - 1;

  logic [NODES-1:0] nv;
  logic [IW-1:0]    ni [NODES];

  // leaves, padded with never-valid entries
  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign nv[LEAVES-1+j] = req[j];
      assign ni[LEAVES-1+j] = IW'(j);
    end else begin : g_pad
      assign nv[LEAVES-1+j] = 1'b0;
      assign ni[LEAVES-1+j] = '0;
    end
  end

  // internal nodes in heap order: children 2k+1 (side 0) and 2k+2 (side 1)
  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    arb_node #(.IW(IW)) u_node (
      .v0(nv[2*k+1]), .i0(ni[2*k+1]),
      .v1(nv[2*k+2]), .i1(ni[2*k+2]),
      .v (nv[k]),     .i (ni[k])
    );
  end

  assign win_vld = nv[0];
  assign win_idx = ni[0];
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  import pci_arb_pkg::*;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (inc && (cnt != '1))     cnt <= cnt + 1'b1;
  end

  assign expire = limit_reached(32'(cnt), 32'(limit));
endmodule

// File: rtl/pci_tree_arbiter.sv
module pci_tree_arbiter
  import pci_arb_pkg::*;
#(
  parameter  int N_REQ = 6,
  parameter  int CNT_W = 8,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_arb_en,
  input  logic [N_REQ-1:0] req_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic [1:0]       park_mode,
  input  logic [IDX_W-1:0] park_idx,
  input  logic [CNT_W-1:0] xfer_limit,
  output logic [N_REQ-1:0] gnt_n
);

  // ---- named events ----
  logic             en_q;
  logic [N_REQ-1:0] req_vec;
  logic             bus_idle;
  logic             data_phase;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic             tgt_vld;
  logic [IDX_W-1:0] tgt_idx;
  logic             gnt_on;
  logic [IDX_W-1:0] owner;
  logic             exp_pend;
  logic             expire_raw;
  logic             expire_evt;
  logic             drop_evt;
  logic             issue_evt;

  assign req_vec    = ~req_n;
  assign bus_idle   = frame_n & irdy_n;
  assign data_phase = ~irdy_n & ~trdy_n;

  // strap capture: follows the strap while reset is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= strap_arb_en;
  end

  arb_tree #(.N(N_REQ), .IW(IDX_W)) u_tree (
    .req    (req_vec),
    .win_vld(win_vld),
    .win_idx(win_idx)
  );

  // target selection: requests first, then parking
  always_comb begin
    tgt_vld = win_vld;
    tgt_idx = win_idx;
    if (!win_vld) begin
      unique case (park_e'(park_mode))
        PARK_LAST: begin
          tgt_vld = 1'b1;
          tgt_idx = owner;
        end
        PARK_FIXED: begin
          tgt_vld = 32'(park_idx) < N_REQ;
          tgt_idx = park_idx;
        end
        default: begin
          tgt_vld = 1'b0;
          tgt_idx = '0;
        end
      endcase
    end
  end

  xfer_counter #(.CW(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (issue_evt),
    .inc   (gnt_on & data_phase),
    .limit (xfer_limit),
    .expire(expire_raw)
  );

  assign expire_evt = gnt_on & expire_raw;
  assign drop_evt   = gnt_on & (~en_q | expire_evt |
                                (bus_idle & (~tgt_vld | (tgt_idx != owner))));
  assign issue_evt  = ~gnt_on & en_q & tgt_vld & (bus_idle | exp_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_on   <= 1'b0;
      owner    <= '0;
      exp_pend <= 1'b0;
    end else begin
      if (issue_evt) begin
        gnt_on   <= 1'b1;
        owner    <= tgt_idx;
        exp_pend <= 1'b0;
      end else if (drop_evt) begin
        gnt_on <= 1'b0;
        if (expire_evt) exp_pend <= 1'b1;
      end
    end
  end

  assign gnt_n = gnt_on ? ~(N_REQ'(1) << owner) : '1;

  // ---- assertions ----
  // R1
  strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> gnt_n == '1);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R3
  prio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (req_vec[win_idx] &&
                 ((32'(req_vec) & below_mask(32'(win_idx))) == 32'd0)));

  // R4
  issue_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_n != '1) && ($past(gnt_n) == '1)) |-> $past(bus_idle | exp_pend));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_on && !bus_idle && !expire_raw && en_q) |=> gnt_n == $past(gnt_n));

  // R6
  owner_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_n != '1) && ($past(gnt_n) != '1)) |-> gnt_n == $past(gnt_n));

  // R8
  limit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> gnt_n == '1);

endmodule

// File: tb/pci_tree_arbiter_tb.sv
module pci_tree_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strap_arb_en = 1'b1;
  logic [NR-1:0] req_n = '1;
  logic          frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [1:0]    park_mode = 2'd0;
  logic [2:0]    park_idx = 3'd0;
  logic [7:0]    xfer_limit = 8'd0;
  logic [NR-1:0] gnt_n;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_tree_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .strap_arb_en(strap_arb_en), .req_n(req_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .park_mode(park_mode), .park_idx(park_idx), .xfer_limit(xfer_limit),
    .gnt_n(gnt_n)
  );

  function automatic int lowest(input logic [NR-1:0] r);
    for (int i = 0; i < NR; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic int gidx(input logic [NR-1:0] g_n);
    for (int i = 0; i < NR; i++) if (!g_n[i]) return i;
    return -1;
  endfunction

  function automatic logic [NR-1:0] g1(input int i);
    return ~(NR'(1) << i);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [NR-1:0] act,
                     input logic [NR-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: gnt_n actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int last, prev_g, cur_g, e;
    void'($urandom(32'd20240611));
    step(3);
    chk(gnt_n == '1, "R2 reset", gnt_n, '1);
    rst_n = 1'b1;

    // priority and first-edge grant
    req_n = ~6'b110100; step(1);
    chk(gnt_n == g1(2), "R3/R9 lowest wins", gnt_n, g1(2));
    req_n = ~6'b110000; step(1);
    chk(gnt_n == '1, "R6 gap on handover", gnt_n, '1);
    step(1);
    chk(gnt_n == g1(4), "R9 next owner", gnt_n, g1(4));
    // busy hold
    frame_n = 1'b0; req_n = ~6'b110001; step(3);
    chk(gnt_n == g1(4), "R5 hold while busy", gnt_n, g1(4));
    frame_n = 1'b1; step(1);
    chk(gnt_n == '1, "R6 gap after busy", gnt_n, '1);
    step(1);
    chk(gnt_n == g1(0), "R3 top priority", gnt_n, g1(0));
    // parking
    req_n = '1; park_mode = 2'd0; step(1);
    chk(gnt_n == '1, "R7 no parking", gnt_n, '1);
    step(2);
    chk(gnt_n == '1, "R7 no parking stays", gnt_n, '1);
    park_mode = 2'd2; park_idx = 3'd3; step(1);
    chk(gnt_n == g1(3), "R7 fixed park", gnt_n, g1(3));
    park_idx = 3'd7; step(2);
    chk(gnt_n == '1, "R7 fixed park out of range", gnt_n, '1);
    park_mode = 2'd1; step(1);
    chk(gnt_n == g1(3), "R7 park last", gnt_n, g1(3));
    req_n = ~6'b100000; step(2);
    chk(gnt_n == g1(5), "R9 to requester 5", gnt_n, g1(5));
    req_n = '1; step(2);
    chk(gnt_n == g1(5), "R7 park last keeps", gnt_n, g1(5));
    // transfer limit
    xfer_limit = 8'd3; req_n = ~6'b100010;
    frame_n = 1'b0; irdy_n = 1'b0; trdy_n = 1'b0; step(3);
    chk(gnt_n == g1(5), "R8 held through limit", gnt_n, g1(5));
    step(1);
    chk(gnt_n == '1, "R8 dropped after limit", gnt_n, '1);
    step(1);
    chk(gnt_n == g1(1), "R4 grant after expiry on busy bus", gnt_n, g1(1));
    xfer_limit = 8'd0; req_n = ~6'b000011; step(20);
    chk(gnt_n == g1(1), "R8 unlimited", gnt_n, g1(1));
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; req_n = '1; park_mode = 2'd0;
    step(3);

    // random phase
    last = 1; prev_g = -1;
    for (int c = 0; c < 4000; c++) begin
      if (c % 200 == 0) begin
        park_mode  = 2'($urandom);
        park_idx   = 3'($urandom);
        e = $urandom % 3;
        xfer_limit = (e == 0) ? 8'd0 : ((e == 1) ? 8'd2 : 8'd5);
      end
      req_n   = NR'($urandom);
      frame_n = ($urandom % 3) != 0;
      irdy_n  = frame_n ? (($urandom % 4) != 0) : 1'($urandom);
      trdy_n  = 1'($urandom);
      @(negedge clk);
      cur_g = gidx(gnt_n);
      chk($onehot0(~gnt_n), "R2 one-hot", gnt_n, gnt_n);
      if (prev_g >= 0 && cur_g >= 0)
        chk(cur_g == prev_g, "R6 direct handover", gnt_n, g1(prev_g));
      if (prev_g >= 0 && !(frame_n & irdy_n) && xfer_limit == 0)
        chk(cur_g == prev_g, "R5 busy hold", gnt_n, g1(prev_g));
      if (prev_g < 0 && cur_g >= 0) begin
        chk((frame_n & irdy_n) || xfer_limit != 0, "R4 issue on idle", gnt_n, '1);
        if (req_n != '1) begin
          e = lowest(~req_n);
          chk(cur_g == e, "R3 random priority", gnt_n, g1(e));
        end else if (park_mode == 2'd1) begin
          chk(cur_g == last, "R7 random park last", gnt_n, g1(last));
        end else if (park_mode == 2'd2 && park_idx < 3'd6) begin
          chk(cur_g == int'(park_idx), "R7 random fixed park", gnt_n, g1(int'(park_idx)));
        end else begin
          chk(1'b0, "R7 grant without target", gnt_n, '1);
        end
      end
      if (cur_g >= 0) last = cur_g;
      prev_g = cur_g;
    end

    // strap off
    req_n = '1; frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
    strap_arb_en = 1'b0; rst_n = 1'b0; step(2);
    rst_n = 1'b1; strap_arb_en = 1'b1;
    req_n = ~6'b111111; park_mode = 2'd2; park_idx = 3'd1;
    for (int k = 0; k < 10; k++) begin
      step(1);
      chk(gnt_n == '1, "R1 strap disabled", gnt_n, '1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule